// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight edge-triggered interrupt inputs, keeps a request register and an in-service register, and raises a single interrupt output toward a processor. Software reaches it through a byte-wide register port with one address bit. Port 0 takes commands and reads back a status register. Port 1 takes the mask and the words that follow an initialization command.

When the processor answers the interrupt, it pulses an acknowledge strobe. In that same cycle the block presents an 8-bit vector, built from a programmed base and the number of the winning input, and moves that input into service. A specific end-of-interrupt command releases the input again. If the request has gone by the time of the acknowledge, the block returns the input-7 vector and changes no in-service state. An initialization flag records whether the part sits in a cascade, and the cascade word is kept on an output for the surrounding logic.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are zero, port-0 reads return the request register, the vector base is 0, the cascade flag is 0 and the interrupt output is low.
- R2: A port-0 write with bit 4 set starts initialization. The next port-1 write is the vector base. If bit 1 of the start word was 0, a cascade word follows. If bit 0 was 1, a mode word follows. After that, port-1 writes set the mask.
- R3: The vector presented during acknowledge is {base[7:3], input number}, so a base of 0x20 yields 0x20 to 0x27.
- R4: Outside initialization a port-1 write loads the mask, and a 1 in bit n keeps input n from raising the output or winning an acknowledge. Port-1 reads return the mask.
- R5: A port-0 write of 0x0B makes port-0 reads return the in-service register, and 0x0A makes them return the request register.
- R6: A port-0 write of 0x60+n (n = 0..7) clears in-service bit n.
- R7: Input 0 has the highest priority and input 7 the lowest. The interrupt output is high exactly when some unmasked request bit has a lower index than every set in-service bit.
- R8: Request bit n is set by a rising edge on input n. It is cleared at the next clock while the input is low, and when that input is acknowledged.
- R9: An acknowledge with an eligible request sets the in-service bit of the highest-priority eligible input and clears its request bit.
- R10: An acknowledge with no eligible request returns {base[7:3], 7} and leaves the in-service register unchanged.
- R11: Starting initialization clears the request and in-service registers, sets the mask to 0xFF and selects request-register read-back. Inputs already high do not count as edges.
- R12: The cascade output is 1 when the last start word had bit 1 equal to 0, and the cascade-word output holds the last cascade word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register port select (0 command/status, 1 mask/init words) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Interrupt inputs, edge triggered |
| irq_out | output | 1 | Interrupt request toward the processor |
| inta | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| inta_vec | output | 8 | Vector valid while inta is high |
| cascaded | output | 1 | Cascade flag from the start word |
| casc_word | output | 8 | Last cascade word written |

## Verification
The bench builds the block at its fixed eight-input width, with an 8-bit vector and a 3-bit input index. At that width every in-service pattern, and every position of the lowest in-service bit against the pending requests, can be reached by random stimulus. The directed part covers both initialization paths: a cascaded start with the mode word, and a single start with the mode word. The random part mixes input toggles, acknowledges, mask writes, specific end-of-interrupt commands and read-back switches, and checks every vector, interrupt output and read-back against a model of the requirements. That mix reaches the input-7 fallback on a request that has vanished, and an end-of-interrupt that arrives together with an acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic grant_t pick_first(input logic [NUM_IN-1:0] v);
        grant_t g;
        g = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (v[i]) begin
                g.vld = 1'b1;
                g.idx = IDX_W'(i);
            end
        end
        return g;
    endfunction

    function automatic logic [NUM_IN-1:0] outrank_mask(input logic [NUM_IN-1:0] svc);
        logic [NUM_IN-1:0] m;
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            seen = seen | svc[i];
            m[i] = ~seen;
        end
        return m;
    endfunction
endpackage

// File: rtl/pic_cmd.sv
module pic_cmd
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_IN-1:0]   mask,
    output logic [BASE_W-1:0]   base,
    output logic                rd_isr,
    output logic                cascaded,
    output logic [DATA_W-1:0]   casc_word,
    output logic                init_clr,
    output logic                eoi_vld,
    output logic [IDX_W-1:0]    eoi_idx
);
    init_st_e st;
    logic     need_casc, need_mode;
    logic     cmd_wr;

    assign cmd_wr   = wr && !addr;
    assign init_clr = cmd_wr && wdata[4];
    assign eoi_vld  = cmd_wr && (st == ST_RUN) && (wdata[4:3] == 2'b00)
                      && (wdata[7:5] == 3'b011);
    assign eoi_idx  = wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            mask      <= '1;
            base      <= '0;
            rd_isr    <= 1'b0;
            cascaded  <= 1'b0;
            casc_word <= '0;
            need_casc <= 1'b0;
            need_mode <= 1'b0;
        end else if (init_clr) begin
            st        <= ST_BASE;
            mask      <= '1;
            rd_isr    <= 1'b0;
            need_casc <= ~wdata[1];
            need_mode <= wdata[0];
            cascaded  <= ~wdata[1];
        end else if (wr && addr) begin
            unique case (st)
                ST_RUN:  mask <= wdata[NUM_IN-1:0];
                ST_BASE: begin
                    base <= wdata[DATA_W-1:IDX_W];
                    st   <= need_casc ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
                end
                ST_CASC: begin
                    casc_word <= wdata;
                    st        <= need_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: st <= ST_RUN;
            endcase
        end else if (cmd_wr && (st == ST_RUN) && (wdata[4:3] == 2'b01) && wdata[1]) begin
            rd_isr <= wdata[0];
        end
    end
endmodule

// File: rtl/pic_reqlatch.sv
module pic_reqlatch
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              clr_all,
    input  logic [NUM_IN-1:0] clr_grant,
    output logic [NUM_IN-1:0] irr
);
    logic [NUM_IN-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            if (clr_all)
                irr <= '0;
            else
                irr <= ((irr | (irq_in & ~prev)) & irq_in) & ~clr_grant;
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  logic [NUM_IN-1:0] irr,
    input  logic [NUM_IN-1:0] mask,
    input  logic [NUM_IN-1:0] isr,
    output grant_t            grant
);
    logic [NUM_IN-1:0] eligible;

    assign eligible = irr & ~mask & outrank_mask(isr);
    assign grant    = pick_first(eligible);
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        irq_in,
    output logic              irq_out,
    input  logic              inta,
    output logic [7:0]        inta_vec,
    output logic              cascaded,
    output logic [7:0]        casc_word
);
    logic [NUM_IN-1:0] mask_q, irr_q, isr_q, clr_grant;
    logic [BASE_W-1:0] base_q;
    logic              rd_isr, init_clr, eoi_vld;
    logic [IDX_W-1:0]  eoi_idx;
    grant_t            grant;

    pic_cmd u_cmd (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mask(mask_q), .base(base_q), .rd_isr(rd_isr), .cascaded(cascaded),
        .casc_word(casc_word), .init_clr(init_clr), .eoi_vld(eoi_vld),
        .eoi_idx(eoi_idx)
    );

    pic_resolver u_res (.irr(irr_q), .mask(mask_q), .isr(isr_q), .grant(grant));

    assign clr_grant = (inta && grant.vld) ? (NUM_IN'(1) << grant.idx) : '0;

    pic_reqlatch u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .clr_all(init_clr),
        .clr_grant(clr_grant), .irr(irr_q)
    );

    always_ff @(posedge clk) begin
        if (rst || init_clr) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~(eoi_vld ? (NUM_IN'(1) << eoi_idx) : '0)) | clr_grant;
        end
    end

    assign irq_out   = grant.vld;
    assign inta_vec  = {base_q, grant.vld ? grant.idx : IDX_W'(NUM_IN - 1)};
    assign bus_rdata = bus_addr ? mask_q : (rd_isr ? isr_q : irr_q);
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [7:0] irq_in,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] mask,
    input logic       irq_out,
    input logic       inta,
    input logic [7:0] inta_vec,
    input logic [4:0] base
);
    a_r7_out_needs_request: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((irr & ~mask) != 8'h00));

    a_r8_irr_needs_level: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~$past(irq_in)) == 8'h00));

    a_r10_spurious_holds_isr: assert property (@(posedge clk) disable iff (rst)
        (inta && !irq_out && !bus_wr) |=> (isr == $past(isr)));

    a_r9_grant_adds_one: assert property (@(posedge clk) disable iff (rst)
        (inta && irq_out && !bus_wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

    a_r3_vec_base: assert property (@(posedge clk) disable iff (rst)
        inta |-> (inta_vec[7:3] == base));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .irq_in(irq_in), .irr(irr_q),
    .isr(isr_q), .mask(mask_q), .irq_out(irq_out), .inta(inta),
    .inta_vec(inta_vec), .base(base_q)
);

// File: tb/pic_ctrl_test.sv
`timescale 1ns/1ps
module pic_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_addr = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] bus_rdata, inta_vec, casc_word;
    logic       irq_out, cascaded;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_mask, m_irr, m_isr, m_prev, m_base, m_casc;
    logic       m_rdisr, m_cascaded, m_nc, m_nm;
    int         m_st;

    always #2.5 clk = ~clk;

    pic_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out), .inta(inta), .inta_vec(inta_vec),
        .cascaded(cascaded), .casc_word(casc_word)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic int best(input logic [7:0] irr, input logic [7:0] msk, input logic [7:0] isr);
        for (int i = 0; i < 8; i++) begin
            if (isr[i]) return -1;
            if (irr[i] && !msk[i]) return i;
        end
        return -1;
    endfunction

    function automatic void model_reset();
        m_mask = 8'hFF; m_irr = 0; m_isr = 0; m_prev = 0; m_base = 0; m_casc = 0;
        m_rdisr = 0; m_cascaded = 0; m_nc = 0; m_nm = 0; m_st = 0;
    endfunction

    // one cycle: drive at negedge, check, update model, advance
    task automatic cycle(input logic w, input logic a, input logic [7:0] d,
                         input logic k, input logic [7:0] inp);
        int g;
        logic [7:0] exp_rd;
        bus_wr = w; bus_addr = a; bus_wdata = d; inta = k; irq_in = inp;
        #1;
        g = best(m_irr, m_mask, m_isr);
        check("R7 irq_out", {7'd0, irq_out}, {7'd0, g >= 0});
        if (k) check(g >= 0 ? "R3/R9 vector" : "R10 spurious vector",
                     inta_vec, {m_base[7:3], g >= 0 ? 3'(g) : 3'd7});
        if (!w) begin
            exp_rd = a ? m_mask : (m_rdisr ? m_isr : m_irr);
            check(a ? "R4 mask read" : "R5 status read", bus_rdata, exp_rd);
        end
        // model next state
        begin
            logic [7:0] clr, eoi;
            clr = (k && g >= 0) ? (8'h01 << g) : 8'h00;
            eoi = 8'h00;
            if (w && !a && d[4]) begin
                m_st = 1; m_mask = 8'hFF; m_rdisr = 0; m_nc = ~d[1]; m_nm = d[0];
                m_cascaded = ~d[1]; m_irr = 0; m_isr = 0;
            end else begin
                if (w && a) begin
                    case (m_st)
                        0: m_mask = d;
                        1: begin m_base = {d[7:3], 3'd0}; m_st = m_nc ? 2 : (m_nm ? 3 : 0); end
                        2: begin m_casc = d; m_st = m_nm ? 3 : 0; end
                        default: m_st = 0;
                    endcase
                end else if (w && !a && m_st == 0) begin
                    if (d[4:3] == 2'b01 && d[1]) m_rdisr = d[0];
                    if (d[4:3] == 2'b00 && d[7:5] == 3'b011) eoi = 8'h01 << d[2:0];
                end
                m_irr = ((m_irr | (inp & ~m_prev)) & inp) & ~clr;
                m_isr = (m_isr & ~eoi) | clr;
            end
            m_prev = inp;
        end
        @(negedge clk);
        bus_wr = 0; inta = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] inp;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        bus_addr = 1; #1; check("R1 mask after reset", bus_rdata, 8'hFF);
        bus_addr = 0; #1; check("R1 request reg after reset", bus_rdata, 8'h00);
        check("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
        check("R1 cascade flag after reset", {7'd0, cascaded}, 8'h00);
        inta = 1; #1; check("R1 base zero", inta_vec, 8'h07); inta = 0;
        @(negedge clk);

        // R2 cascaded init: start, base, cascade word, mode
        cycle(1, 0, 8'h11, 0, 8'h00);
        cycle(1, 1, 8'h20, 0, 8'h00);
        cycle(1, 1, 8'h04, 0, 8'h00);
        cycle(1, 1, 8'h01, 0, 8'h00);
        check("R12 cascade flag", {7'd0, cascaded}, 8'h01);
        check("R12 cascade word", casc_word, 8'h04);
        cycle(1, 1, 8'h00, 0, 8'h00);          // R2 now a mask write
        cycle(0, 1, 8'h00, 0, 8'h00);

        // R8/R7 priority: inputs 5 and 2 rise together, 2 wins
        cycle(0, 0, 8'h00, 0, 8'h24);
        cycle(0, 0, 8'h00, 1, 8'h24);          // R9 grant input 2
        cycle(1, 0, 8'h0B, 0, 8'h24);          // R5 select in-service
        cycle(0, 0, 8'h00, 0, 8'h24);
        cycle(0, 0, 8'h00, 1, 8'h24);          // input 5 outranked? no, 5 < none; isr bit2 blocks 5
        cycle(1, 0, 8'h62, 0, 8'h24);          // R6 clear in-service 2
        cycle(0, 0, 8'h00, 1, 8'h24);          // now grants 5
        cycle(1, 0, 8'h65, 0, 8'h00);          // R6
        // R10 request vanishes before acknowledge
        cycle(0, 0, 8'h00, 0, 8'h08);
        cycle(0, 0, 8'h00, 0, 8'h00);
        cycle(0, 0, 8'h00, 1, 8'h00);
        cycle(0, 0, 8'h00, 0, 8'h00);
        // R4 masked input does not interrupt
        cycle(1, 1, 8'h01, 0, 8'h00);
        cycle(0, 0, 8'h00, 0, 8'h01);
        cycle(0, 0, 8'h00, 1, 8'h01);
        cycle(1, 1, 8'h00, 0, 8'h01);          // unmask; level held, request kept
        cycle(0, 1, 8'h00, 0, 8'h01);
        cycle(1, 0, 8'h0A, 0, 8'h01);          // R5 back to request reg
        cycle(0, 0, 8'h00, 0, 8'h00);

        // R11/R2 single init with mode word; held input is not an edge
        cycle(0, 0, 8'h00, 0, 8'h10);
        cycle(1, 0, 8'h13, 0, 8'h10);
        cycle(0, 1, 8'h00, 0, 8'h10);
        cycle(1, 1, 8'h48, 0, 8'h10);
        cycle(1, 1, 8'h01, 0, 8'h10);
        check("R12 single flag", {7'd0, cascaded}, 8'h00);
        check("R12 cascade word kept", casc_word, 8'h04);
        cycle(1, 1, 8'h00, 0, 8'h10);
        cycle(0, 0, 8'h00, 0, 8'h10);
        cycle(0, 0, 8'h00, 1, 8'h00);

        // random mix
        inp = 8'h00;
        for (int n = 0; n < 6000; n++) begin
            logic w, a, k;
            logic [7:0] d;
            int r;
            inp = inp ^ (($urandom % 3 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00);
            k = ($urandom % 4 == 0);
            w = ($urandom % 6 == 0);
            a = $urandom % 2;
            d = 8'h00;
            if (w) begin
                r = $urandom % 4;
                if (r == 0) begin a = 1; d = ($urandom % 2) ? 8'h00 : 8'($urandom); end
                else if (r == 1) begin a = 0; d = ($urandom % 2) ? 8'h0B : 8'h0A; end
                else begin a = 0; d = 8'h60 + 8'($urandom % 8); end
            end
            cycle(w, a, d, k, inp);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule